// File: doc/BRIEF.md
# Maskable Interrupt Status Register with Output Pin

This block gathers a set of single-cycle event pulses into a sticky status byte. Each event has its own enable bit, and an interrupt output pin is driven from the pending events that are enabled. The block sits inside a management register file. One register word holds the enable mask in its upper half and the status bits in its lower half. The register file writes that word, reads it, and raises a read strobe whenever software reads it. A polarity bit from a separate control register sets the level at which the pin is active.

Status bits latch on an event pulse and stay set until the word is read. The read strobe returns the status as it stood before the clear. An event that arrives in the same cycle as the clearing read is kept for the next read. The status half of the word is read-only, so writes change only the enables.

A disabled event is still recorded in the status. It simply does not drive the pin. By default the pin follows the registered state with no extra delay. A parameter can add one register stage in front of the polarity stage.

Top module: `irq_status_ctrl`

## Requirements
- R1: While reset is asserted and after it, read data is all zeros. The pin sits at its inactive level, which is 0 when `pol_high_i`=1 and 1 when `pol_high_i`=0.
- R2: An event pulse on `evt_i[k]` sets status bit k, which is read-data bit k, on the next clock edge. The bit then stays set through idle cycles with no read.
- R3: In a cycle with `rd_strobe_i` high, `rd_data_o[7:0]` shows the status before the clear. After that edge, every status bit whose event was not pulsing reads 0.
- R4: An event pulse in the same cycle as `rd_strobe_i` leaves that status bit set after the edge.
- R5: A write with `wr_en_i` high loads `wr_data_i[15:8]` into the enable byte, seen at `rd_data_o[15:8]`. `wr_data_i[7:0]` is ignored, and the status byte is not changed by the write.
- R6: The pin is active exactly when some status bit k and enable bit k are both 1. A status bit with its enable at 0 is recorded but leaves the pin inactive.
- R7: With `pol_high_i`=1 the active pin level is 1. With `pol_high_i`=0 it is 0. A change of polarity takes effect in the same cycle.
- R8: Enabling an event whose status bit is already set activates the pin right after the write edge, with no new event needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| evt_i | input | 8 | Single-cycle event pulses, one per condition |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | 16 | Write data; only bits 15:8 are used |
| rd_strobe_i | input | 1 | Register read strobe; clears the status |
| rd_data_o | output | 16 | Register word: {enable byte, status byte} |
| pol_high_i | input | 1 | 1 = pin active high, 0 = pin active low |
| irq_o | output | 1 | Interrupt pin |

## Verification
The assertions check four things on every cycle. Events are latched into the status byte. The status byte clears to exactly the events of a read cycle. The enable byte holds unless it is written, and loads the written byte when it is. The pin level agrees with the visible enable and status bytes and the polarity. Some behaviours can only be shown by the bench's scenarios. These are the values during reset for both polarities, the pre-clear value returned in a read cycle, a pending bit that was disabled and later enabled, and a write whose low byte is all ones leaving the status unchanged.

// File: rtl/irq_pkg.sv
package irq_pkg;
   // Upper bound on the number of event lines supported by one register word.
   localparam int unsigned MAX_EVT = 16;

   // How the pin is derived from the pending state.
   typedef enum bit {
      PIN_COMB = 1'b0,  // pin follows the registered state directly
      PIN_REG  = 1'b1   // one extra register stage before polarity
   } pin_mode_e;

   // Apply output polarity to an active-high pending flag.
   function automatic logic apply_pol(input logic active, input logic pol_high);
      return pol_high ? active : ~active;
   endfunction
endpackage

// File: rtl/irq_sticky_bank.sv
module irq_sticky_bank #(
   parameter int unsigned N = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] evt_i,
   input  logic         clr_i,
   output logic [N-1:0] status_o
);
   for (genvar k = 0; k < N; k++) begin : g_bit
      logic st_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)          st_q <= 1'b0;
         else if (evt_i[k])   st_q <= 1'b1;  // new event wins over clear
         else if (clr_i)      st_q <= 1'b0;
      end
      assign status_o[k] = st_q;
   end
endmodule

// File: rtl/irq_enable_reg.sv
module irq_enable_reg #(
   parameter int unsigned N = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr_en_i,
   input  logic [N-1:0] wr_val_i,
   output logic [N-1:0] en_o
);
   logic [N-1:0] en_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       en_q <= '0;
      else if (wr_en_i) en_q <= wr_val_i;
   end
   assign en_o = en_q;
endmodule

// File: rtl/irq_pin_drive.sv
module irq_pin_drive
   import irq_pkg::*;
#(
   parameter int unsigned N    = 8,
   parameter pin_mode_e   MODE = PIN_COMB
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] status_i,
   input  logic [N-1:0] en_i,
   input  logic         pol_high_i,
   output logic         pin_o
);
   logic any_pending;
   logic active;

   assign any_pending = |(status_i & en_i);

   if (MODE == PIN_REG) begin : g_reg
      logic act_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) act_q <= 1'b0;
         else        act_q <= any_pending;
      end
      assign active = act_q;
   end else begin : g_comb
      assign active = any_pending;
   end

   assign pin_o = apply_pol(active, pol_high_i);
endmodule

// File: rtl/irq_status_ctrl.sv
module irq_status_ctrl
   import irq_pkg::*;
#(
   parameter int unsigned NUM_EVT  = 8,
   parameter pin_mode_e   PIN_MODE = PIN_COMB,
   localparam int unsigned REG_W   = 2 * NUM_EVT
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_EVT-1:0] evt_i,
   input  logic               wr_en_i,
   input  logic [REG_W-1:0]   wr_data_i,
   input  logic               rd_strobe_i,
   output logic [REG_W-1:0]   rd_data_o,
   input  logic               pol_high_i,
   output logic               irq_o
);
   if (NUM_EVT < 1 || NUM_EVT > MAX_EVT) begin : g_bad_width
      $error("irq_status_ctrl: NUM_EVT must be within 1..%0d", MAX_EVT);
   end

   logic [NUM_EVT-1:0] status;
   logic [NUM_EVT-1:0] enable;

   irq_sticky_bank #(.N(NUM_EVT)) u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .evt_i    (evt_i),
      .clr_i    (rd_strobe_i),
      .status_o (status)
   );

   irq_enable_reg #(.N(NUM_EVT)) u_en (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en_i  (wr_en_i),
      .wr_val_i (wr_data_i[REG_W-1:NUM_EVT]),
      .en_o     (enable)
   );

   irq_pin_drive #(.N(NUM_EVT), .MODE(PIN_MODE)) u_pin (
      .clk        (clk),
      .rst_n      (rst_n),
      .status_i   (status),
      .en_i       (enable),
      .pol_high_i (pol_high_i),
      .pin_o      (irq_o)
   );

   assign rd_data_o = {enable, status};
endmodule

// File: rtl/irq_status_chk.sv
module irq_status_chk
   import irq_pkg::*;
#(
   parameter int unsigned NUM_EVT  = 8,
   parameter pin_mode_e   PIN_MODE = PIN_COMB,
   localparam int unsigned REG_W   = 2 * NUM_EVT
) (
   input logic               clk,
   input logic               rst_n,
   input logic [NUM_EVT-1:0] evt_i,
   input logic               wr_en_i,
   input logic [REG_W-1:0]   wr_data_i,
   input logic               rd_strobe_i,
   input logic [REG_W-1:0]   rd_data_o,
   input logic               pol_high_i,
   input logic               irq_o
);
   logic [NUM_EVT-1:0] st_v, en_v;
   assign st_v = rd_data_o[NUM_EVT-1:0];
   assign en_v = rd_data_o[REG_W-1:NUM_EVT];

   // R2 / R4: every pulsed event is visible in the status after the edge
   a_r2_event_latched: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((st_v & $past(evt_i)) == $past(evt_i)));

   // R2: without a read, no status bit falls
   a_r2_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_strobe_i |=> ((st_v & $past(st_v)) == $past(st_v)));

   // R3 / R4: after a read the status equals exactly the events of that cycle
   a_r3_clear_on_read: assert property (@(posedge clk) disable iff (!rst_n)
      rd_strobe_i |=> (st_v == $past(evt_i)));

   // R5: enable byte loads the written upper byte
   a_r5_write_loads: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en_i |=> (en_v == $past(wr_data_i[REG_W-1:NUM_EVT])));

   // R5: enable byte holds without a write
   a_r5_enable_holds: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en_i |=> $stable(en_v));

   // R6 / R7: pin level agrees with visible register contents and polarity
   if (PIN_MODE == PIN_COMB) begin : g_chk_comb
      a_r6_pin_level: assert property (@(posedge clk) disable iff (!rst_n)
         irq_o == ((|(st_v & en_v)) ~^ pol_high_i));
   end else begin : g_chk_reg
      a_r6_pin_level: assert property (@(posedge clk) disable iff (!rst_n)
         1'b1 |=> (irq_o == ($past(|(st_v & en_v)) ~^ pol_high_i)));
   end
endmodule

bind irq_status_ctrl irq_status_chk #(.NUM_EVT(NUM_EVT), .PIN_MODE(PIN_MODE)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .evt_i       (evt_i),
   .wr_en_i     (wr_en_i),
   .wr_data_i   (wr_data_i),
   .rd_strobe_i (rd_strobe_i),
   .rd_data_o   (rd_data_o),
   .pol_high_i  (pol_high_i),
   .irq_o       (irq_o)
);

// File: tb/sim_irq_status_ctrl.sv
module sim_irq_status_ctrl;
   localparam int PERIOD = 10;
   localparam int WATCHDOG_CYC = 5000;

   typedef struct {
      logic [15:0] rd;
      logic        irq;
      string       req;
   } exp_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  evt_i = '0;
   logic        wr_en_i = 1'b0;
   logic [15:0] wr_data_i = '0;
   logic        rd_strobe_i = 1'b0;
   logic [15:0] rd_data_o;
   logic        pol_high_i = 1'b1;
   logic        irq_o;

   exp_t scb[$];
   int   n_cmp = 0;
   int   n_bad = 0;
   bit   done = 1'b0;

   logic [7:0] m_en = '0;
   logic [7:0] m_st = '0;

   always #(PERIOD/2) clk = ~clk;

   irq_status_ctrl u0 (
      .clk         (clk),
      .rst_n       (rst_n),
      .evt_i       (evt_i),
      .wr_en_i     (wr_en_i),
      .wr_data_i   (wr_data_i),
      .rd_strobe_i (rd_strobe_i),
      .rd_data_o   (rd_data_o),
      .pol_high_i  (pol_high_i),
      .irq_o       (irq_o)
   );

   // Apply one cycle of stimulus just after a rising edge, queue the
   // expected outputs of this cycle, then advance the reference model.
   task automatic step(input logic [7:0] evt, input logic wr, input logic [15:0] wd,
                       input logic rd, input logic pol, input string req);
      exp_t e;
      evt_i = evt; wr_en_i = wr; wr_data_i = wd; rd_strobe_i = rd; pol_high_i = pol;
      e.rd  = {m_en, m_st};
      e.irq = (|(m_en & m_st)) ? pol : ~pol;
      e.req = req;
      scb.push_back(e);
      if (rst_n) begin
         m_st = rd ? evt : (m_st | evt);
         if (wr) m_en = wd[15:8];
      end
      @(posedge clk); #1;
   endtask

   // Monitor: compare one queued item per falling edge
   always @(negedge clk) begin
      if (scb.size() > 0) begin
         exp_t e;
         e = scb.pop_front();
         n_cmp++;
         if (rd_data_o !== e.rd || irq_o !== e.irq) begin
            n_bad++;
            $display("FAIL %s: rd_data=%h irq=%b, expected rd_data=%h irq=%b",
                     e.req, rd_data_o, irq_o, e.rd, e.irq);
         end
      end
   end

   initial begin
      @(posedge clk); #1;
      // R1: reset values for both polarities
      step(8'h00, 1'b0, 16'h0, 1'b0, 1'b1, "R1");
      step(8'hFF, 1'b1, 16'hFFFF, 1'b1, 1'b1, "R1");
      step(8'h00, 1'b0, 16'h0, 1'b0, 1'b0, "R1");
      rst_n = 1'b1;
      step(8'h00, 1'b0, 16'h0, 1'b0, 1'b1, "R1");
      // R2: latch and hold, enables still off -> pin inactive (R6)
      step(8'h05, 1'b0, 16'h0, 1'b0, 1'b1, "R2");
      step(8'h00, 1'b0, 16'h0, 1'b0, 1'b1, "R6");
      step(8'h00, 1'b0, 16'h0, 1'b0, 1'b1, "R2");
      step(8'h10, 1'b0, 16'h0, 1'b0, 1'b1, "R2");
      step(8'h00, 1'b0, 16'h0, 1'b0, 1'b1, "R2");
      // R5: write enables with low byte all ones; status must not change
      step(8'h00, 1'b1, 16'h02FF, 1'b0, 1'b1, "R5");
      step(8'h00, 1'b0, 16'h0, 1'b0, 1'b1, "R5");
      step(8'h00, 1'b0, 16'h0, 1'b0, 1'b0, "R6");
      // R8: enable a bit already pending
      step(8'h00, 1'b1, 16'h0400, 1'b0, 1'b1, "R8");
      step(8'h00, 1'b0, 16'h0, 1'b0, 1'b1, "R8");
      // R7: polarity flip takes effect in the same cycle
      step(8'h00, 1'b0, 16'h0, 1'b0, 1'b0, "R7");
      step(8'h00, 1'b0, 16'h0, 1'b0, 1'b1, "R7");
      // R3: read returns pre-clear value, then status clears
      step(8'h00, 1'b0, 16'h0, 1'b1, 1'b1, "R3");
      step(8'h00, 1'b0, 16'h0, 1'b0, 1'b1, "R3");
      step(8'h00, 1'b0, 16'h0, 1'b0, 1'b0, "R3");
      // R4: event coinciding with the read survives
      step(8'h81, 1'b0, 16'h0, 1'b0, 1'b1, "R4");
      step(8'h80, 1'b0, 16'h0, 1'b1, 1'b1, "R4");
      step(8'h00, 1'b0, 16'h0, 1'b0, 1'b1, "R4");
      step(8'h00, 1'b1, 16'h8000, 1'b0, 1'b1, "R6");
      step(8'h00, 1'b0, 16'h0, 1'b0, 1'b1, "R6");
      step(8'h00, 1'b0, 16'h0, 1'b1, 1'b0, "R3");
      step(8'h00, 1'b0, 16'h0, 1'b0, 1'b0, "R7");
      // R5 with read and write in the same cycle
      step(8'h22, 1'b0, 16'h0, 1'b0, 1'b1, "R2");
      step(8'h00, 1'b1, 16'h20AA, 1'b1, 1'b1, "R5");
      step(8'h00, 1'b0, 16'h0, 1'b0, 1'b1, "R5");
      // walk each event bit through latch, enable and clear
      for (int k = 0; k < 8; k++) begin
         step(8'h01 << k, 1'b1, {8'h01 << k, 8'h00}, 1'b0, 1'b0, "R2");
         step(8'h00, 1'b0, 16'h0, 1'b1, 1'b0, "R6");
         step(8'h00, 1'b0, 16'h0, 1'b0, 1'b0, "R3");
      end
      @(negedge clk); #1;
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      #(PERIOD * WATCHDOG_CYC);
      if (!done) begin
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog: run did not complete, expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end
endmodule